// File: doc/BRIEF.md
# CPU Frame Mailbox Register

This block gives a host processor a byte-wide path for moving whole frames into and out of a switch. All frame traffic goes through one host register, the frame port, at address `3'b011`. A second register at address `3'b100` reports status. To send a frame, the host writes a four-byte descriptor to the frame port and then writes the payload bytes to the same address. The block forwards each payload byte to the switch-side transmit stream, tagged with the destination port the host chose. The stream carries nothing that marks the frame as coming from the host. The block drops any frame that declares fewer than 64 bytes and records the drop in a sticky error flag.

On the receive side the switch delivers frames as a byte stream with sideband fields. The block holds up to two frames in two buffer slots and raises `irq` while a frame is waiting. Each read of the frame port returns the next byte of the oldest frame: first a six-byte descriptor, then the payload. The size field in the descriptor tells the host exactly how many payload reads to make. When the host reads the last payload byte, that slot is freed. The next queued frame, if there is one, then becomes current.

The transmit sequencer has six states. `TX_SZLO → TX_SZHI → TX_PORT → TX_STAT` each take one descriptor write. `TX_STAT` moves on to `TX_FWD` when size ≥ 64, to `TX_DROP` when 1 ≤ size < 64, and back to `TX_SZLO` when size = 0. `TX_FWD` and `TX_DROP` return to `TX_SZLO` on the size-th payload write. The receive presenter has two states. `RD_HEADER` counts six descriptor reads and then moves to `RD_PAYLOAD`. `RD_PAYLOAD` returns to `RD_HEADER` on the last payload read.

Top module: `cpu_frame_mailbox`

## Requirements
- R1: After reset, `irq`, `tx_valid` and `tx_last` are 0, `rx_ready` is 1, and reads of address 3'b100 and 3'b011 both return 0.
- R2: The transmit descriptor is four writes to address 3'b011, in this order: size bits 7:0, size bits 10:8 (in data bits 2:0), destination port (data bits 2:0), status byte.
- R3: For a frame with size ≥ 64, each payload write appears on `tx_data` with `tx_valid` high in the cycle after the write. `tx_port` and `tx_status` carry the descriptor values, and `tx_last` is high only with the size-th byte.
- R4: A frame with size < 64 never raises `tx_valid`. It sets status bit 0, and its size payload writes are consumed, so the next write starts a new descriptor.
- R5: Status bit 0 stays set until the host writes to address 3'b100 with data bit 0 set, which clears it.
- R6: A frame that completes on the receive stream (the `rx_last` byte accepted) raises `irq`. Status bit 1 mirrors `irq`.
- R7: The receive descriptor is six reads of address 3'b011, in this order: size bits 7:0, size bits 10:8 (in bits 2:0), source port (bits 2:0), status, VLAN bits 15:8, VLAN bits 7:0. Port, status and VLAN are the sideband values sampled with the `rx_last` byte.
- R8: After the descriptor, payload reads return the stored bytes in arrival order. There are exactly size of them.
- R9: Two frames can be held. With both slots full, `rx_ready` is 0. Reading the last payload byte of the current frame drops `irq` if no other frame is held, and keeps it high if another frame is held.
- R10: A read of address 3'b011 with no frame held returns 0 and does not disturb the read sequence of the next frame.
- R11: Received bytes beyond DEPTH (default 128) are discarded, and the size field reports DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Host register address |
| host_wr | input | 1 | One-cycle host write strobe |
| host_rd | input | 1 | One-cycle host read strobe (advances the frame port) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr`, valid before the read strobe edge |
| irq | output | 1 | A received frame is waiting |
| tx_valid | output | 1 | Transmit stream byte valid |
| tx_data | output | 8 | Transmit stream byte |
| tx_last | output | 1 | Final byte of the transmitted frame |
| tx_port | output | 3 | Destination port of the current transmit frame |
| tx_status | output | 8 | Status byte of the current transmit frame |
| rx_valid | input | 1 | Receive stream byte valid |
| rx_data | input | 8 | Receive stream byte |
| rx_last | input | 1 | Final byte of a received frame |
| rx_ready | output | 1 | Block can accept a receive byte |
| rx_port | input | 3 | Source port, sampled with the last byte |
| rx_status | input | 8 | Frame status, sampled with the last byte |
| rx_vlan | input | 16 | VLAN tag, sampled with the last byte |

## Verification
The hardest state to reach is both receive slots full while the host is partway through the current frame. Only in that state are the back-pressure of `rx_ready` and the retained `irq` after a pop both visible. The bench fills both slots before any host read, checks back-pressure, then drains one frame and confirms `irq` stays high. Truncation is reached by streaming a frame two bytes longer than the buffer. The transmit size sweep runs through 0, 1, 63, 64, 65 and 100, so that both the drop path and the forward path end on their exact final write.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam logic [2:0] ADDR_FRAME = 3'b011;
    localparam logic [2:0] ADDR_STAT  = 3'b100;
    localparam int SIZE_W  = 11;
    localparam int PORT_W  = 3;
    localparam int MIN_LEN = 64;
    localparam int HDR_RX  = 6;

    typedef enum logic [2:0] {
        TX_SZLO, TX_SZHI, TX_PORT, TX_STAT, TX_FWD, TX_DROP
    } tx_state_e;

    typedef enum logic {
        RD_HEADER, RD_PAYLOAD
    } rd_state_e;
endpackage

// File: rtl/mbx_tx_inject.sv
module mbx_tx_inject
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wdata,
    input  logic              err_clr,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic [PORT_W-1:0] tx_port,
    output logic [7:0]        tx_status,
    output logic              err_flag
);
    tx_state_e         state_q, state_d;
    logic [SIZE_W-1:0] size_q, cnt_q;
    logic [PORT_W-1:0] port_q;
    logic [7:0]        stat_q;
    logic              final_byte, short_frame;

    assign final_byte  = (cnt_q == size_q - SIZE_W'(1));
    assign short_frame = (size_q < SIZE_W'(MIN_LEN));
    assign tx_port     = port_q;
    assign tx_status   = stat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_SZLO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (state_q)
                TX_SZLO: state_d = TX_SZHI;
                TX_SZHI: state_d = TX_PORT;
                TX_PORT: state_d = TX_STAT;
                TX_STAT: begin
                    if (!short_frame)            state_d = TX_FWD;
                    else if (size_q == '0)       state_d = TX_SZLO;
                    else                         state_d = TX_DROP;
                end
                TX_FWD, TX_DROP: if (final_byte) state_d = TX_SZLO;
                default: state_d = TX_SZLO;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
            tx_data  <= '0;
            size_q   <= '0;
            cnt_q    <= '0;
            port_q   <= '0;
            stat_q   <= '0;
            err_flag <= 1'b0;
        end else begin
            tx_valid <= 1'b0;
            tx_last  <= 1'b0;
            if (err_clr) err_flag <= 1'b0;
            if (wr_en) begin
                unique case (state_q)
                    TX_SZLO: size_q[7:0]        <= wdata;
                    TX_SZHI: size_q[SIZE_W-1:8] <= wdata[SIZE_W-9:0];
                    TX_PORT: port_q             <= wdata[PORT_W-1:0];
                    TX_STAT: begin
                        stat_q <= wdata;
                        cnt_q  <= '0;
                        if (short_frame) err_flag <= 1'b1;
                    end
                    TX_FWD: begin
                        tx_valid <= 1'b1;
                        tx_data  <= wdata;
                        tx_last  <= final_byte;
                        cnt_q    <= cnt_q + SIZE_W'(1);
                    end
                    TX_DROP: cnt_q <= cnt_q + SIZE_W'(1);
                    default: ;
                endcase
            end
        end
    end

    // R4
    drop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_DROP) |=> !tx_valid);
    // R3
    last_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);
    // R3
    fwd_only_long_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_FWD) |-> !short_frame);
endmodule

// File: rtl/mbx_rx_store.sv
module mbx_rx_store
    import mbx_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic [PORT_W-1:0] rx_port,
    input  logic [7:0]        rx_status,
    input  logic [15:0]       rx_vlan,
    output logic              rx_ready,
    input  logic              pop,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [7:0]        rd_byte,
    output logic              head_full,
    output logic [CNT_W-1:0]  head_len,
    output logic [PORT_W-1:0] head_port,
    output logic [7:0]        head_stat,
    output logic [15:0]       head_vlan
);
    logic [7:0]        mem [2][DEPTH];
    logic [1:0]        full_q;
    logic [CNT_W-1:0]  len_q  [2];
    logic [PORT_W-1:0] port_q [2];
    logic [7:0]        stat_q [2];
    logic [15:0]       vlan_q [2];
    logic              wsel_q, rsel_q;
    logic [CNT_W-1:0]  wcnt_q;
    logic              take, room;

    assign rx_ready = !full_q[wsel_q];
    assign take     = rx_valid && rx_ready;
    assign room     = (wcnt_q < CNT_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (take && room) mem[wsel_q][wcnt_q[IDX_W-1:0]] <= rx_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= '0;
            wsel_q <= 1'b0;
            rsel_q <= 1'b0;
            wcnt_q <= '0;
            for (int s = 0; s < 2; s++) begin
                len_q[s]  <= '0;
                port_q[s] <= '0;
                stat_q[s] <= '0;
                vlan_q[s] <= '0;
            end
        end else begin
            if (take) begin
                if (rx_last) begin
                    full_q[wsel_q] <= 1'b1;
                    len_q[wsel_q]  <= room ? wcnt_q + CNT_W'(1) : wcnt_q;
                    port_q[wsel_q] <= rx_port;
                    stat_q[wsel_q] <= rx_status;
                    vlan_q[wsel_q] <= rx_vlan;
                    wsel_q         <= !wsel_q;
                    wcnt_q         <= '0;
                end else if (room) begin
                    wcnt_q <= wcnt_q + CNT_W'(1);
                end
            end
            if (pop) begin
                full_q[rsel_q] <= 1'b0;
                rsel_q         <= !rsel_q;
            end
        end
    end

    assign head_full = full_q[rsel_q];
    assign head_len  = len_q[rsel_q];
    assign head_port = port_q[rsel_q];
    assign head_stat = stat_q[rsel_q];
    assign head_vlan = vlan_q[rsel_q];
    assign rd_byte   = mem[rsel_q][rd_idx];

    // R11
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wcnt_q <= CNT_W'(DEPTH));
    // R9
    pop_has_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_full);
endmodule

// File: rtl/mbx_rx_present.sv
module mbx_rx_present
    import mbx_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              head_full,
    input  logic [CNT_W-1:0]  head_len,
    input  logic [PORT_W-1:0] head_port,
    input  logic [7:0]        head_stat,
    input  logic [15:0]       head_vlan,
    input  logic [7:0]        rd_byte,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              pop,
    output logic [7:0]        data_out
);
    rd_state_e        state_q, state_d;
    logic [CNT_W-1:0] idx_q;
    logic [SIZE_W-1:0] size_w;
    logic             step, hdr_done, pay_done;

    assign size_w   = SIZE_W'(head_len);
    assign step     = rd_en && head_full;
    assign hdr_done = (idx_q == CNT_W'(HDR_RX - 1));
    assign pay_done = (idx_q == head_len - CNT_W'(1));
    assign pop      = step && (state_q == RD_PAYLOAD) && pay_done;
    assign rd_idx   = idx_q[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_HEADER;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (step) begin
            unique case (state_q)
                RD_HEADER:  if (hdr_done) state_d = RD_PAYLOAD;
                RD_PAYLOAD: if (pay_done) state_d = RD_HEADER;
                default:    state_d = RD_HEADER;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else if (step) begin
            if ((state_q == RD_HEADER && hdr_done) || pop) idx_q <= '0;
            else                                          idx_q <= idx_q + CNT_W'(1);
        end
    end

    always_comb begin
        data_out = 8'h00;
        if (head_full) begin
            if (state_q == RD_PAYLOAD) data_out = rd_byte;
            else begin
                unique case (idx_q)
                    CNT_W'(0): data_out = size_w[7:0];
                    CNT_W'(1): data_out = 8'(size_w[SIZE_W-1:8]);
                    CNT_W'(2): data_out = 8'(head_port);
                    CNT_W'(3): data_out = head_stat;
                    CNT_W'(4): data_out = head_vlan[15:8];
                    default:   data_out = head_vlan[7:0];
                endcase
            end
        end
    end

    // R8
    payload_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RD_PAYLOAD) |-> (idx_q < head_len));
    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !head_full |=> ($stable(idx_q) && $stable(state_q)));
endmodule

// File: rtl/cpu_frame_mailbox.sv
module cpu_frame_mailbox
    import mbx_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              irq,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic [PORT_W-1:0] tx_port,
    output logic [7:0]        tx_status,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    output logic              rx_ready,
    input  logic [PORT_W-1:0] rx_port,
    input  logic [7:0]        rx_status,
    input  logic [15:0]       rx_vlan
);
    logic              wr_frame, rd_frame, err_clr, err_flag;
    logic              pop, head_full;
    logic [IDX_W-1:0]  rd_idx;
    logic [7:0]        rd_byte, frame_byte;
    logic [CNT_W-1:0]  head_len;
    logic [PORT_W-1:0] head_port;
    logic [7:0]        head_stat;
    logic [15:0]       head_vlan;

    assign wr_frame = host_wr && (host_addr == ADDR_FRAME);
    assign rd_frame = host_rd && (host_addr == ADDR_FRAME);
    assign err_clr  = host_wr && (host_addr == ADDR_STAT) && host_wdata[0];
    assign irq      = head_full;

    mbx_tx_inject u_tx (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_frame), .wdata(host_wdata),
        .err_clr(err_clr), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_last(tx_last), .tx_port(tx_port), .tx_status(tx_status),
        .err_flag(err_flag)
    );

    mbx_rx_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_last(rx_last), .rx_port(rx_port), .rx_status(rx_status),
        .rx_vlan(rx_vlan), .rx_ready(rx_ready), .pop(pop), .rd_idx(rd_idx),
        .rd_byte(rd_byte), .head_full(head_full), .head_len(head_len),
        .head_port(head_port), .head_stat(head_stat), .head_vlan(head_vlan)
    );

    mbx_rx_present #(.DEPTH(DEPTH)) u_present (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_frame), .head_full(head_full),
        .head_len(head_len), .head_port(head_port), .head_stat(head_stat),
        .head_vlan(head_vlan), .rd_byte(rd_byte), .rd_idx(rd_idx),
        .pop(pop), .data_out(frame_byte)
    );

    always_comb begin
        unique case (host_addr)
            ADDR_FRAME: host_rdata = frame_byte;
            ADDR_STAT:  host_rdata = {6'b0, irq, err_flag};
            default:    host_rdata = 8'h00;
        endcase
    end

    // R10
    empty_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && host_addr == ADDR_FRAME) |-> (host_rdata == 8'h00));
    // R6
    irq_from_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !(rx_valid && rx_ready && rx_last)) |=> !irq);
endmodule

// File: tb/test_cpu_frame_mailbox.sv
module test_cpu_frame_mailbox;
    localparam int DEPTH = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        irq, tx_valid, tx_last, rx_ready;
    logic [7:0]  tx_data, tx_status;
    logic [2:0]  tx_port;
    logic        rx_valid = 1'b0, rx_last = 1'b0;
    logic [7:0]  rx_data = '0, rx_status = '0;
    logic [2:0]  rx_port = '0;
    logic [15:0] rx_vlan = '0;

    int n_checks = 0, n_fail = 0;

    always #10 clk = !clk;

    cpu_frame_mailbox #(.DEPTH(DEPTH)) i_cpu_frame_mailbox (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .irq(irq), .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .tx_port(tx_port), .tx_status(tx_status), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
        .rx_port(rx_port), .rx_status(rx_status), .rx_vlan(rx_vlan)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
        host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    function automatic logic [7:0] tx_byte(input int size, input int i);
        return 8'((i * 3 + size) & 8'hFF);
    endfunction

    function automatic logic [7:0] rx_byte(input int seed, input int i);
        return 8'((i * 5 + seed) & 8'hFF);
    endfunction

    task automatic send_tx(input int size, input int port, input int stat);
        int wrong_valid = 0;
        host_write(3'b011, 8'(size & 8'hFF));
        host_write(3'b011, 8'((size >> 8) & 7));
        host_write(3'b011, 8'(port));
        host_write(3'b011, 8'(stat));
        for (int i = 0; i < size; i++) begin
            host_write(3'b011, tx_byte(size, i));
            if (size >= 64) begin
                check("R3 tx_valid", int'(tx_valid), 1);
                check("R3 tx_data", int'(tx_data), int'(tx_byte(size, i)));
                check("R3 tx_last", int'(tx_last), (i == size - 1) ? 1 : 0);
                if (i == 0) begin
                    check("R2 tx_port", int'(tx_port), port);
                    check("R2 tx_status", int'(tx_status), stat);
                end
            end else if (tx_valid) wrong_valid++;
        end
        if (size < 64) check("R4 no forward of short frame", wrong_valid, 0);
    endtask

    task automatic send_rx(input int len, input int port, input int stat, input int vlan);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            while (!rx_ready) @(negedge clk);
            rx_valid = 1'b1; rx_data = rx_byte(len + port, i);
            rx_last = (i == len - 1);
            rx_port = 3'(port); rx_status = 8'(stat); rx_vlan = 16'(vlan);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0;
    endtask

    task automatic read_rx(input int len, input int port, input int stat, input int vlan);
        logic [7:0] d;
        int stored, bad;
        stored = (len > DEPTH) ? DEPTH : len;
        host_read(3'b011, d); check("R7 size lo", int'(d), stored & 8'hFF);
        host_read(3'b011, d); check("R7 size hi", int'(d), (stored >> 8) & 7);
        host_read(3'b011, d); check("R7 src port", int'(d), port);
        host_read(3'b011, d); check("R7 status", int'(d), stat);
        host_read(3'b011, d); check("R7 vlan hi", int'(d), (vlan >> 8) & 8'hFF);
        host_read(3'b011, d); check("R7 vlan lo", int'(d), vlan & 8'hFF);
        bad = 0;
        for (int i = 0; i < stored; i++) begin
            host_read(3'b011, d);
            if (d != rx_byte(len + port, i)) bad++;
        end
        check(len > DEPTH ? "R11 truncated payload" : "R8 payload order", bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 irq", int'(irq), 0);
        check("R1 tx_valid", int'(tx_valid), 0);
        check("R1 tx_last", int'(tx_last), 0);
        check("R1 rx_ready", int'(rx_ready), 1);
        host_read(3'b100, d); check("R1 status", int'(d), 0);
        host_read(3'b011, d); check("R1 frame port", int'(d), 0);

        // R2 R3 R4 transmit size sweep
        send_tx(64, 5, 8'hA1);
        host_read(3'b100, d); check("R4 no err on 64", int'(d[0]), 0);
        send_tx(63, 2, 8'h11);
        host_read(3'b100, d); check("R4 err on 63", int'(d[0]), 1);
        send_tx(65, 7, 8'h3C);
        host_read(3'b100, d); check("R5 err sticky", int'(d[0]), 1);
        host_write(3'b100, 8'h00);
        host_read(3'b100, d); check("R5 write zero keeps err", int'(d[0]), 1);
        host_write(3'b100, 8'h01);
        host_read(3'b100, d); check("R5 err cleared", int'(d[0]), 0);
        send_tx(0, 1, 8'h00);
        host_read(3'b100, d); check("R4 err on size 0", int'(d[0]), 1);
        send_tx(1, 3, 8'h02);
        send_tx(100, 0, 8'hFF);
        host_write(3'b100, 8'h01);

        // R10 empty reads do not disturb
        host_read(3'b011, d); check("R10 empty read", int'(d), 0);
        host_read(3'b011, d); check("R10 empty read again", int'(d), 0);
        check("R6 irq idle", int'(irq), 0);

        // R6 R7 R8 single frames of several lengths
        send_rx(1, 4, 8'h55, 16'h1234);
        check("R6 irq raised", int'(irq), 1);
        host_read(3'b100, d); check("R6 status bit1", int'(d[1]), 1);
        read_rx(1, 4, 8'h55, 16'h1234);
        check("R9 irq drops", int'(irq), 0);
        send_rx(64, 6, 8'h0F, 16'hBEEF);
        read_rx(64, 6, 8'h0F, 16'hBEEF);

        // R9 two frames held, back-pressure, irq retained
        send_rx(5, 1, 8'h77, 16'h0102);
        send_rx(70, 2, 8'h88, 16'hF00D);
        check("R9 rx_ready low when full", int'(rx_ready), 0);
        read_rx(5, 1, 8'h77, 16'h0102);
        check("R9 irq kept with queued frame", int'(irq), 1);
        check("R9 rx_ready after pop", int'(rx_ready), 1);
        read_rx(70, 2, 8'h88, 16'hF00D);
        check("R9 irq drops at end", int'(irq), 0);

        // R11 truncation
        send_rx(DEPTH + 2, 3, 8'h99, 16'h8001);
        read_rx(DEPTH + 2, 3, 8'h99, 16'h8001);
        send_rx(DEPTH, 0, 8'h01, 16'h0000);
        read_rx(DEPTH, 0, 8'h01, 16'h0000);
        check("R10 irq after drain", int'(irq), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule